// File: doc/BRIEF.md
# Keypad Digit Encoder and Serializer

This block watches ten digit-key switch lines (keys 0 to 9, each low while held) and turns the pressed key into its 4-bit binary-coded-decimal value. It also flags whether any digit key is held. Operator keys are handled elsewhere and never reach this block.

The block is paced by a digit-slot strobe from the chip's timing logic, which pulses once per 4-clock digit slot. On each strobe the current key code and the any-key flag are captured into a holding register. Over the next four clocks the captured code is shifted out on a single serial line, one bit per clock and least-significant bit first. Between slots the serial line rests at 0.

The sequencer has two states. `ST_IDLE` drives 0 on the serial line. `ST_SEND` drives the bit that the bit counter selects. There are four transitions:
- `ST_IDLE -> ST_SEND` when a strobe is sampled (capture).
- `ST_SEND -> ST_SEND` on a strobe (restart with a fresh capture).
- `ST_SEND -> ST_SEND` with the counter advancing when no strobe arrives before the last bit.
- `ST_SEND -> ST_IDLE` after the last bit when no strobe arrives.

Top module: `keypad_digit_serializer`

## Requirements
- R1: A key line held low encodes as its own key number on `key_code`, 0 to 9 in binary. Bit 0 (weight 1) is set for every odd key, and bit 2 (weight 4) is set for keys 4 to 7.
- R2: When several key lines are low together, the lowest-numbered key is the one encoded.
- R3: `key_valid` is 1 after a capture exactly when at least one key line was low at that capture. When no key was down, `key_code` is 0 and `key_valid` is 0.
- R4: `key_code` and `key_valid` change only on a clock edge where `slot_strobe` is sampled high. Key changes between strobes have no effect on them or on the bits being sent.
- R5: After an edge that samples `slot_strobe` high, `ser_out` carries captured code bit 0, then bit 1, then bit 2, then bit 3, during the four clock cycles that follow.
- R6: `ser_out` is 0 outside those four cycles, and it is 0 throughout a slot whose capture saw no key.
- R7: A strobe that arrives while a slot is still being sent restarts the slot: it captures again, and bit 0 of the new code appears in the next cycle.
- R8: While reset is asserted, `ser_out`, `key_valid` and `key_code` are all 0 and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_n | input | 10 | Digit key lines, bit i is key i, low while pressed |
| slot_strobe | input | 1 | Start-of-digit-slot pulse from the timing block |
| ser_out | output | 1 | Serial code bit, LSB first |
| key_valid | output | 1 | Captured any-key flag |
| key_code | output | 4 | Captured BCD code of the pressed key |

## Verification
The bench steps every single key through a full slot, so a swapped or mis-weighted encoder bit shows up either as a wrong parallel code or as a wrong serial bit. It presses combinations such as 3 with 7, 0 with 9, and all ten keys together. An encoder that lets the highest key win fails on these. It changes the pressed key in the middle of a slot and leaves gaps between strobes. A design that captures continuously, or keeps shifting past four bits, then shows the new key early or puts nonzero bits on an idle line. A strobe arriving two cycles into a slot catches a sequencer that ignores a restart or restarts without capturing again.

// File: rtl/kds_pkg.sv
package kds_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } kds_state_e;
endpackage

// File: rtl/kds_key_encoder.sv
module kds_key_encoder #(
    parameter int NUM_KEYS = 10,
    parameter int CODE_W   = 4
) (
    input  logic [NUM_KEYS-1:0] key_n,
    output logic [CODE_W-1:0]   code,
    output logic                any_key
);
    // Scan from the top down so the lowest pressed key is written last and wins.
    always_comb begin
        code = '0;
        for (int i = NUM_KEYS - 1; i >= 0; i--) begin
            if (!key_n[i]) begin
                code = CODE_W'(i);
            end
        end
    end

    assign any_key = ~(&key_n);
endmodule

// File: rtl/kds_slot_fsm.sv
module kds_slot_fsm
    import kds_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_strobe,
    output logic load,
    output logic shift_en,
    output logic sending
);
    localparam int CNT_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CODE_W - 1);

    kds_state_e       state_q, state_d;
    logic [CNT_W-1:0] bit_cnt_q, bit_cnt_d;

    always_comb begin
        state_d   = state_q;
        bit_cnt_d = bit_cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (slot_strobe) begin
                    state_d   = ST_SEND;
                    bit_cnt_d = '0;
                end
            end
            ST_SEND: begin
                if (slot_strobe) begin
                    bit_cnt_d = '0;
                end else if (bit_cnt_q == LAST_BIT) begin
                    state_d   = ST_IDLE;
                    bit_cnt_d = '0;
                end else begin
                    bit_cnt_d = bit_cnt_q + 1'b1;
                end
            end
            default: begin
                state_d   = ST_IDLE;
                bit_cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
        end else begin
            state_q   <= state_d;
            bit_cnt_q <= bit_cnt_d;
        end
    end

    always_comb begin
        load     = slot_strobe;
        sending  = 1'b0;
        shift_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                sending = 1'b0;
            end
            ST_SEND: begin
                sending  = 1'b1;
                shift_en = !slot_strobe;
            end
            default: begin
                sending = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/kds_code_hold.sv
module kds_code_hold #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code_d,
    input  logic              valid_d,
    output logic [CODE_W-1:0] code_q,
    output logic              valid_q,
    output logic              ser_bit,
    input  logic              shift_en,
    input  logic              sending
);
    logic [CODE_W-1:0] shreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            valid_q <= 1'b0;
            shreg_q <= '0;
        end else if (load) begin
            code_q  <= code_d;
            valid_q <= valid_d;
            shreg_q <= code_d;
        end else if (shift_en) begin
            shreg_q <= {1'b0, shreg_q[CODE_W-1:1]};
        end
    end

    assign ser_bit = sending & shreg_q[0];
endmodule

// File: rtl/keypad_digit_serializer.sv
module keypad_digit_serializer #(
    parameter int NUM_KEYS = 10,
    parameter int CODE_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] key_n,
    input  logic                slot_strobe,
    output logic                ser_out,
    output logic                key_valid,
    output logic [CODE_W-1:0]   key_code
);
    logic [CODE_W-1:0] enc_code;
    logic              enc_any;
    logic              load, shift_en, sending;

    kds_key_encoder #(.NUM_KEYS(NUM_KEYS), .CODE_W(CODE_W)) u_enc (
        .key_n   (key_n),
        .code    (enc_code),
        .any_key (enc_any)
    );

    kds_slot_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_strobe (slot_strobe),
        .load        (load),
        .shift_en    (shift_en),
        .sending     (sending)
    );

    kds_code_hold #(.CODE_W(CODE_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .code_d   (enc_code),
        .valid_d  (enc_any),
        .code_q   (key_code),
        .valid_q  (key_valid),
        .ser_bit  (ser_out),
        .shift_en (shift_en),
        .sending  (sending)
    );
endmodule

// File: rtl/kds_checker.sv
module kds_checker #(
    parameter int NUM_KEYS = 10,
    parameter int CODE_W   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_KEYS-1:0] key_n,
    input logic                slot_strobe,
    input logic                ser_out,
    input logic                key_valid,
    input logic [CODE_W-1:0]   key_code
);
    localparam int POS_W = $clog2(CODE_W + 2);
    localparam logic [POS_W-1:0] POS_DONE = POS_W'(CODE_W + 1);

    // Cycle position inside a slot: 0 never started, 1..CODE_W sending, CODE_W+1 done.
    logic [POS_W-1:0] pos_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (slot_strobe) begin
            pos_q <= POS_W'(1);
        end else if (pos_q != '0 && pos_q != POS_DONE) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    p_code_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> (key_code <= CODE_W'(NUM_KEYS - 1)));

    p_no_key_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |-> (key_code == '0 && !ser_out));

    p_capture_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_strobe |=> (key_valid == $past(~(&key_n))));

    p_hold_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_strobe |=> ($stable(key_code) && $stable(key_valid)));

    p_first_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        slot_strobe |=> (ser_out == key_code[0]));

    p_bit_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q != '0 && pos_q != POS_DONE) |-> (ser_out == key_code[pos_q - 1'b1]));

    p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == '0 || pos_q == POS_DONE) |-> !ser_out);

    always_comb begin
        if (!rst_n) begin
            a_reset_r8: assert (!ser_out && !key_valid && key_code == '0);
        end
    end
endmodule

bind keypad_digit_serializer kds_checker #(.NUM_KEYS(NUM_KEYS), .CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_n       (key_n),
    .slot_strobe (slot_strobe),
    .ser_out     (ser_out),
    .key_valid   (key_valid),
    .key_code    (key_code)
);

// File: tb/keypad_digit_serializer_tb.sv
module keypad_digit_serializer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] key_n = 10'h3FF;
    logic       slot_strobe = 1'b0;
    logic       ser_out, key_valid;
    logic [3:0] key_code;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int m_code = 0, m_valid = 0, m_idx = -1;
    string tag = "R8";
    bit done = 1'b0;

    always #5 clk = ~clk;

    keypad_digit_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .key_n(key_n), .slot_strobe(slot_strobe),
        .ser_out(ser_out), .key_valid(key_valid), .key_code(key_code)
    );

    task automatic cmp(input string rq, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", rq, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            finish_run();
        end
    end

    function automatic int lowest_key(input logic [9:0] k);
        for (int i = 0; i < 10; i++) if (!k[i]) return i;
        return -1;
    endfunction

    function automatic logic [9:0] press(input int a, input int b, input int c);
        logic [9:0] v = 10'h3FF;
        if (a >= 0) v[a] = 1'b0;
        if (b >= 0) v[b] = 1'b0;
        if (c >= 0) v[c] = 1'b0;
        return v;
    endfunction

    // One clock: drive, update the reference at the edge, compare mid-low phase.
    task automatic step(input logic [9:0] k, input logic s);
        key_n = k;
        slot_strobe = s;
        @(posedge clk);
        if (s) begin
            int lk = lowest_key(k);
            m_valid = (lk >= 0) ? 1 : 0;
            m_code  = (lk >= 0) ? lk : 0;
            m_idx   = 0;
        end else if (m_idx >= 0) begin
            m_idx = (m_idx == 3) ? -1 : m_idx + 1;
        end
        @(negedge clk);
        cmp(tag, "key_code", int'(key_code), m_code);
        cmp(tag, "key_valid", int'(key_valid), m_valid);
        cmp((m_idx >= 0) ? tag : "R6", "ser_out", int'(ser_out),
            (m_idx >= 0) ? ((m_code >> m_idx) & 1) : 0);
    endtask

    task automatic slot(input logic [9:0] k);
        step(k, 1'b1);
        for (int i = 0; i < 3; i++) step(k, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: outputs held at zero under reset
        cmp("R8", "ser_out", int'(ser_out), 0);
        cmp("R8", "key_valid", int'(key_valid), 0);
        cmp("R8", "key_code", int'(key_code), 0);
        rst_n = 1'b1;
        step(10'h3FF, 1'b0);

        tag = "R1";
        for (int k = 0; k < 10; k++) slot(press(k, -1, -1));
        tag = "R5";
        slot(press(9, -1, -1));
        slot(press(6, -1, -1));

        tag = "R2";
        slot(press(3, 7, -1));
        slot(press(0, 9, -1));
        slot(press(5, 6, 8));
        slot(10'h000);

        tag = "R3";
        slot(10'h3FF);
        tag = "R6";
        for (int i = 0; i < 3; i++) step(press(7, -1, -1), 1'b0);

        tag = "R4";
        step(press(5, -1, -1), 1'b1);
        step(press(2, -1, -1), 1'b0);
        step(10'h3FF, 1'b0);
        step(press(1, -1, -1), 1'b0);
        for (int i = 0; i < 4; i++) step(press(8, -1, -1), 1'b0);

        tag = "R7";
        step(press(6, -1, -1), 1'b1);
        step(press(6, -1, -1), 1'b0);
        step(press(9, -1, -1), 1'b1);
        for (int i = 0; i < 5; i++) step(press(9, -1, -1), 1'b0);
        step(press(3, -1, -1), 1'b1);
        step(press(4, -1, -1), 1'b1);
        for (int i = 0; i < 4; i++) step(10'h3FF, 1'b0);

        done = 1'b1;
        finish_run();
    end
endmodule